// File: doc/BRIEF.md
# Shift and Bit-Manipulation Unit

This block runs the single-operand byte operations of a small 8-bit datapath. It covers one-position logical and arithmetic shifts, rotates through the carry flag, and a nibble swap. It also moves bits between a register and the T flag, and sets or clears individual status flags. Each operation returns a result byte, a write enable for that byte, and the next value of the 8-bit status register.

The caller supplies four inputs: an operation code, the operand byte, a 3-bit bit index and the current status register. All outputs are registered and appear one clock after the inputs are sampled. Each operation changes only its own fixed set of flags and passes every other status bit through unchanged. The status register bits, from 7 down to 0, are I, T, H, S, V, N, Z, C.

Top module: `shift_bit_unit`

## Requirements
- R1: While `rst_n` is low, `res_o`, `sreg_o` and `wr_en_o` are all zero.
- R2: Op 1 (logical left) shifts the operand up one bit, fills bit 0 with 0 and puts old bit 7 in C. Op 2 (logical right) shifts it down one bit, fills bit 7 with 0 and puts old bit 0 in C.
- R3: Op 3 (rotate left) puts the incoming C in bit 0 and old bit 7 in C. Op 4 (rotate right) puts the incoming C in bit 7 and old bit 0 in C.
- R4: Op 5 (arithmetic right) moves bits 7..1 to positions 6..0, keeps bit 7 and puts old bit 0 in C.
- R5: For ops 1 to 5, the flags are set as follows. Z (bit 1) is set when the result is zero. N (bit 2) equals result bit 7. V (bit 3) is N XOR C. S (bit 4) is N XOR V. I, T and H (bits 7, 6, 5) are unchanged.
- R6: Op 6 exchanges the two nibbles of the operand and leaves the status register unchanged.
- R7: Op 7 copies operand bit `bsel_i` into T (bit 6), changes no other flag and does not write a result.
- R8: Op 8 returns the operand with bit `bsel_i` replaced by T and leaves the status register unchanged.
- R9: Op 9 sets and op 10 clears status bit `bsel_i`. No other status bit changes and no result is written.
- R10: `wr_en_o` is 1 for ops 1 to 6 and 8, and 0 otherwise. Op 0 and codes 11 to 15 leave the status register unchanged and return the operand.
- R11: Outputs appear on the clock edge that samples the inputs, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| opnd_i | input | 8 | Operand byte |
| bsel_i | input | 3 | Bit index for T transfer and flag set/clear |
| sreg_i | input | 8 | Current status register |
| res_o | output | 8 | Result byte |
| sreg_o | output | 8 | Next status register |
| wr_en_o | output | 1 | Result write enable |

## Verification
Every shift and rotate is swept over all 256 operands with the carry in at both values. A rotate that ignored the incoming carry, or a shift that filled from the wrong end, would miss half of these vectors. Bit transfer and flag set/clear are swept over all eight indices with mixed status patterns, which catches flags leaking into neighbouring bits or an off-by-one index. Operand 0x01 under logical right and 0x80 under logical left give a zero result with C set, so Z and V must both be computed from the result, not from the operand.

// File: rtl/shift_bit_unit.sv
module shift_bit_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] opnd_i,
  input  logic [2:0]   bsel_i,
  input  logic [7:0]   sreg_i,
  output logic [W-1:0] res_o,
  output logic [7:0]   sreg_o,
  output logic         wr_en_o
);
  localparam int FC = 0, FZ = 1, FN = 2, FV = 3, FS = 4, FT = 6;
  localparam int HALF = W / 2;

  logic [W-1:0] res_d;
  logic [7:0]   sreg_d;
  logic         we_d;
  logic         cout;
  logic         is_shift;

  always_comb begin
    res_d    = opnd_i;
    sreg_d   = sreg_i;
    we_d     = 1'b0;
    cout     = 1'b0;
    is_shift = 1'b0;
    unique case (op_i)
      4'd1: begin res_d = {opnd_i[W-2:0], 1'b0};          cout = opnd_i[W-1]; is_shift = 1'b1; end
      4'd2: begin res_d = {1'b0, opnd_i[W-1:1]};          cout = opnd_i[0];   is_shift = 1'b1; end
      4'd3: begin res_d = {opnd_i[W-2:0], sreg_i[FC]};    cout = opnd_i[W-1]; is_shift = 1'b1; end
      4'd4: begin res_d = {sreg_i[FC], opnd_i[W-1:1]};    cout = opnd_i[0];   is_shift = 1'b1; end
      4'd5: begin res_d = {opnd_i[W-1], opnd_i[W-1:1]};   cout = opnd_i[0];   is_shift = 1'b1; end
      4'd6: begin res_d = {opnd_i[HALF-1:0], opnd_i[W-1:HALF]}; we_d = 1'b1; end
      4'd7: sreg_d[FT] = opnd_i[bsel_i];
      4'd8: begin res_d[bsel_i] = sreg_i[FT]; we_d = 1'b1; end
      4'd9:  sreg_d[bsel_i] = 1'b1;
      4'd10: sreg_d[bsel_i] = 1'b0;
      default: ;
    endcase
    if (is_shift) begin
      we_d       = 1'b1;
      sreg_d[FC] = cout;
      sreg_d[FZ] = (res_d == '0);
      sreg_d[FN] = res_d[W-1];
      sreg_d[FV] = res_d[W-1] ^ cout;
      sreg_d[FS] = res_d[W-1] ^ (res_d[W-1] ^ cout);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o   <= '0;
      sreg_o  <= '0;
      wr_en_o <= 1'b0;
    end else begin
      res_o   <= res_d;
      sreg_o  <= sreg_d;
      wr_en_o <= we_d;
    end
  end
endmodule

module shift_bit_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] op_i,
  input logic [7:0] opnd_i,
  input logic [2:0] bsel_i,
  input logic [7:0] sreg_i,
  input logic [7:0] res_o,
  input logic [7:0] sreg_o,
  input logic       wr_en_o
);
  always @(negedge clk)
    if (!rst_n)
      a_r1_reset_clear: assert (res_o == 8'h00 && sreg_o == 8'h00 && !wr_en_o);

  a_r2_lsl: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 4'd1 |=> res_o == {$past(opnd_i[6:0]), 1'b0} && sreg_o[0] == $past(opnd_i[7]));

  a_r3_rol_carry_in: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 4'd3 |=> res_o[0] == $past(sreg_i[0]) && sreg_o[0] == $past(opnd_i[7]));

  a_r5_upper_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i >= 4'd1 && op_i <= 4'd5) |=> sreg_o[7:5] == $past(sreg_i[7:5]) && sreg_o[4] == (sreg_o[2] ^ sreg_o[3]));

  a_r6_swap: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 4'd6 |=> res_o == {$past(opnd_i[3:0]), $past(opnd_i[7:4])} && sreg_o == $past(sreg_i));

  a_r9_one_bit_changes: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd9 || op_i == 4'd10) |=> $countones(sreg_o ^ $past(sreg_i)) <= 1 && !wr_en_o);

  a_r10_idle_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd0 || op_i > 4'd10) |=> !wr_en_o && sreg_o == $past(sreg_i) && res_o == $past(opnd_i));
endmodule

bind shift_bit_unit shift_bit_unit_chk u_chk (.*);

// File: tb/shift_bit_unit_test.sv
module shift_bit_unit_test;
  localparam time TCLK = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] opnd_i = '0;
  logic [2:0] bsel_i = '0;
  logic [7:0] sreg_i = '0;
  logic [7:0] res_o, sreg_o;
  logic       wr_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  shift_bit_unit uut (.clk(clk), .rst_n(rst_n), .op_i(op_i), .opnd_i(opnd_i),
                      .bsel_i(bsel_i), .sreg_i(sreg_i), .res_o(res_o),
                      .sreg_o(sreg_o), .wr_en_o(wr_en_o));

  always #(TCLK/2) clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model written arithmetically from the requirements
  task automatic model(input int op, input int a, input int b, input int s,
                       output int r, output int ns, output int we);
    int c, n, v, z;
    int cin;
    cin = s % 2;
    r = a; ns = s; we = 0; c = -1;
    case (op)
      1: begin r = (a * 2) % 256;               c = a / 128; end
      2: begin r = a / 2;                       c = a % 2; end
      3: begin r = (a * 2) % 256 + cin;         c = a / 128; end
      4: begin r = a / 2 + 128 * cin;           c = a % 2; end
      5: begin r = a / 2 + (a / 128) * 128;     c = a % 2; end
      6: begin r = (a % 16) * 16 + a / 16; we = 1; end
      7: begin
           if (((a >> b) % 2) == 1) ns = s | 64; else ns = s & ~64;
         end
      8: begin
           we = 1;
           if (((s >> 6) % 2) == 1) r = a | (1 << b); else r = a & ~(1 << b);
         end
      9:  ns = s | (1 << b);
      10: ns = s & ~(1 << b) & 255;
      default: ;
    endcase
    if (c >= 0) begin
      we = 1;
      z = (r == 0) ? 1 : 0;
      n = r / 128;
      v = n ^ c;
      ns = (s & 8'he0) + ((n ^ v) << 4) + (v << 3) + (n << 2) + (z << 1) + c;
    end
  endtask

  task automatic run(string req, int op, int a, int b, int s);
    int er, es, ew;
    @(negedge clk);
    op_i = op[3:0]; opnd_i = a[7:0]; bsel_i = b[2:0]; sreg_i = s[7:0];
    model(op, a, b, s, er, es, ew);
    @(negedge clk);
    check({req, " result"}, int'(res_o), er);
    check({req, " status"}, int'(sreg_o), es);
    check({req, " write enable"}, int'(wr_en_o), ew);
  endtask

  initial begin
    #(TCLK * 190000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    op_i = 4'd6; opnd_i = 8'h5a; sreg_i = 8'hff;
    repeat (3) @(negedge clk);
    check("R1 reset result", int'(res_o), 0);
    check("R1 reset status", int'(sreg_o), 0);
    check("R1 reset write enable", int'(wr_en_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 one-cycle latency", int'(res_o), 8'ha5);

    run("R2 lsl zero result", 1, 8'h80, 0, 8'h00);
    run("R2 lsr zero result", 2, 8'h01, 0, 8'hff);

    for (int a = 0; a < 256; a++)
      for (int cin = 0; cin < 2; cin++) begin
        int s;
        s = ((a * 29) & 8'hfe) | cin;
        run("R2 R5 lsl", 1, a, 0, s);
        run("R2 R5 lsr", 2, a, 0, s);
        run("R3 R5 rol", 3, a, 0, s);
        run("R3 R5 ror", 4, a, 0, s);
        run("R4 R5 asr", 5, a, 0, s);
      end

    for (int a = 0; a < 256; a++)
      run("R6 swap", 6, a, 0, (a * 7) & 255);

    for (int a = 0; a < 256; a += 3)
      for (int b = 0; b < 8; b++) begin
        run("R7 bst", 7, a, b, (a ^ 8'h4c) & 255);
        run("R8 bld T=0", 8, a, b, 8'hbf);
        run("R8 bld T=1", 8, a, b, 8'h40);
      end

    for (int p = 0; p < 4; p++)
      for (int b = 0; b < 8; b++) begin
        int s;
        s = (p == 0) ? 8'h00 : (p == 1) ? 8'hff : (p == 2) ? 8'ha5 : 8'h5a;
        run("R9 flag set", 9, 8'h3c, b, s);
        run("R9 flag clear", 10, 8'hc3, b, s);
      end

    run("R10 nop", 0, 8'h77, 3, 8'h99);
    for (int op = 11; op < 16; op++)
      run("R10 unused code", op, op * 13, op % 8, op * 11);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule